// File: doc/BRIEF.md
# Half-Duplex Transmit Collision Retry Controller

This block sequences one frame transmission on a shared, half-duplex Ethernet medium. The host raises a request. While the block reports that it is sending, an external serialiser pulses a byte strobe for each byte it puts on the wire, and it marks the last byte with a frame-end pulse. A collision input can interrupt an attempt at any point. The block compares the bytes already sent with a programmable threshold. An early collision sends the block into a random backoff, timed by an external random timer, and the frame then restarts from its first byte. A late collision aborts the frame with no retry.

When the frame ends, the block sets a done flag or an error flag and records a 32-bit status word. The status word holds the outcome bits, the number of collisions seen and the number of bytes sent in the final attempt. The host can always get the block back to idle in either of two ways: by clearing the request, or by pulsing a soft reset. Neither path sets a flag. Retries are limited, so a medium that keeps colliding ends in an excessive-collision abort.

Top module: `hdx_tx_retry_ctrl`

## Requirements
- R1: After synchronous reset, `req`, `tx_go`, `bo_start`, `done_flag` and `err_flag` are 0, `tsv` is 0 and `thr_q` is 64.
- R2: A `req_set` pulse while idle makes `req` and `tx_go` read 1 one cycle later. A `req_set` pulse during a frame has no effect.
- R3: A `frame_end` pulse while sending, with no collision in the same cycle, sets `done_flag` and clears `req` one cycle later. `tsv` then holds bit 30 = 1, bits 20:16 = the number of collisions so far, and bits 15:0 = the byte strobes counted in this attempt before the `frame_end` cycle.
- R4: A collision while sending, with the attempt's byte count (strobes before the collision cycle) at or below `thr_q`, drops `tx_go` and pulses `bo_start` for one cycle, and `req` stays 1. A `bo_done` pulse then raises `tx_go` again one cycle later, and the byte count restarts at 0.
- R5: A collision with the byte count above `thr_q` sets `err_flag` and clears `req` without a backoff. `tsv` then holds bit 31 = 1, bit 29 = 1, bits 20:16 = collisions including this one, and bits 15:0 = the byte count.
- R6: An early collision during the 16th attempt aborts the frame. `err_flag` is set, and `tsv` holds bit 31 = 1, bit 28 = 1, bit 29 = 0 and bits 20:16 = 16.
- R7: When `coll` and `frame_end` arrive in the same cycle, the collision decides the outcome and `done_flag` stays 0.
- R8: `thr_we` loads `thr_in` into the threshold, which is visible on `thr_q` one cycle later and used for the next collision.
- R9: While `tx_soft_rst` is 1, the block is idle (`req` = `tx_go` = 0), and collisions, frame ends and requests are ignored. Flags and `tsv` are left unchanged. After it falls, a new `req_set` starts a frame.
- R10: `req_clr` during a frame or a backoff returns the block to idle one cycle later, with no flag set and `tsv` unchanged.
- R11: `flag_clr` clears both flags one cycle later. If a flag-setting event falls in the same cycle, the flag is set.
- R12: While idle, `coll`, `frame_end` and `bo_done` change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set | input | 1 | Host pulse: request transmission of one frame |
| req_clr | input | 1 | Host pulse: cancel the frame and force idle |
| tx_soft_rst | input | 1 | Host level: hold transmit logic in reset |
| flag_clr | input | 1 | Host pulse: clear done and error flags |
| thr_we | input | 1 | Write strobe for the late-collision threshold |
| thr_in | input | CNT_W | New threshold value in bytes |
| byte_stb | input | 1 | One byte has been sent on the wire |
| frame_end | input | 1 | Last byte of the frame has been sent |
| coll | input | 1 | Collision detected on the medium |
| bo_done | input | 1 | Random backoff timer has expired |
| req | output | 1 | Transmit request bit (1 while a frame is in progress) |
| tx_go | output | 1 | Serialiser may send bytes of the current attempt |
| bo_start | output | 1 | One-cycle pulse that starts the random backoff timer |
| done_flag | output | 1 | Frame completed successfully |
| err_flag | output | 1 | Frame aborted |
| thr_q | output | CNT_W | Current late-collision threshold |
| tsv | output | 32 | Transmit status word of the last finished frame |

## Verification
Two pairs of events can land in the same clock cycle. A collision can arrive together with the frame-end pulse of the same attempt, and a flag can be set in the same cycle the host clears it. The bench drives both pairs deliberately. In the first case it expects a backoff pulse and no done flag, then a clean completion that reports one collision. In the second case it expects the flag to stay set and to clear only on a later clear pulse. Random frames with random thresholds and byte counts are compared against a bench model that sorts each collision as early or late from the byte count.

// File: rtl/hdx_tx_pkg.sv
// Package: shared state type and status-word bit positions for the
// half-duplex transmit retry controller.
package hdx_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEND    = 2'd1,
        ST_BACKOFF = 2'd2
    } tx_state_t;

    localparam int TSV_W          = 32;
    localparam int TSV_ABORT_BIT  = 31;
    localparam int TSV_OK_BIT     = 30;
    localparam int TSV_LATE_BIT   = 29;
    localparam int TSV_EXC_BIT    = 28;
    localparam int TSV_COLL_LSB   = 16;
    localparam int TSV_COLL_W     = 5;
    localparam int TSV_BYTES_W    = 16;
endpackage

// File: rtl/hdx_sat_ctr.sv
// Saturating up-counter with synchronous clear.
// Assumes: clear has priority over increment; holds at all-ones.
module hdx_sat_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count events, stop at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc && (cnt != {W{1'b1}}))
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/hdx_tx_seq.sv
// Transmit sequencer: idle / sending / backoff, with one-cycle event
// outputs for the datapath. Assumes the early/late decision and the
// last-attempt indication are computed outside from registered counts.
// Priority inside a frame: soft reset, host cancel, collision, frame end.
module hdx_tx_seq
    import hdx_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      soft_rst,
    input  logic      req_set,
    input  logic      req_clr,
    input  logic      coll,
    input  logic      frame_end,
    input  logic      bo_done,
    input  logic      early,
    input  logic      last_try,
    output tx_state_t state,
    output logic      ev_start,
    output logic      ev_restart,
    output logic      ev_backoff,
    output logic      ev_done,
    output logic      ev_late,
    output logic      ev_excess
);
    tx_state_t nxt;

    // Next-state and event decode.
    always_comb begin
        nxt        = state;
        ev_start   = 1'b0;
        ev_restart = 1'b0;
        ev_backoff = 1'b0;
        ev_done    = 1'b0;
        ev_late    = 1'b0;
        ev_excess  = 1'b0;
        if (soft_rst) begin
            nxt = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_set) begin
                        nxt      = ST_SEND;
                        ev_start = 1'b1;
                    end
                end
                ST_SEND: begin
                    if (req_clr) begin
                        nxt = ST_IDLE;
                    end else if (coll) begin
                        if (!early) begin
                            ev_late = 1'b1;
                            nxt     = ST_IDLE;
                        end else if (last_try) begin
                            ev_excess = 1'b1;
                            nxt       = ST_IDLE;
                        end else begin
                            ev_backoff = 1'b1;
                            nxt        = ST_BACKOFF;
                        end
                    end else if (frame_end) begin
                        ev_done = 1'b1;
                        nxt     = ST_IDLE;
                    end
                end
                ST_BACKOFF: begin
                    if (req_clr) begin
                        nxt = ST_IDLE;
                    end else if (bo_done) begin
                        nxt        = ST_SEND;
                        ev_restart = 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end
endmodule

// File: rtl/hdx_tx_retry_ctrl.sv
// Top: half-duplex transmit collision retry controller.
// Holds the late-collision threshold, the done/error flags and the
// status word; counts bytes per attempt and collisions per frame.
// Assumes byte_stb only matters while tx_go is high, and that a strobe
// in the same cycle as a collision or frame end is not counted.
module hdx_tx_retry_ctrl
    import hdx_tx_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int THR_RESET  = 64,
    parameter int MAX_TRIES  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_set,
    input  logic             req_clr,
    input  logic             tx_soft_rst,
    input  logic             flag_clr,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] thr_in,
    input  logic             byte_stb,
    input  logic             frame_end,
    input  logic             coll,
    input  logic             bo_done,
    output logic             req,
    output logic             tx_go,
    output logic             bo_start,
    output logic             done_flag,
    output logic             err_flag,
    output logic [CNT_W-1:0] thr_q,
    output logic [TSV_W-1:0] tsv
);
    localparam int CW = $clog2(MAX_TRIES + 1);

    tx_state_t        state;
    logic             ev_start, ev_restart, ev_backoff;
    logic             ev_done, ev_late, ev_excess;
    logic [CNT_W-1:0] byte_cnt;
    logic [CW-1:0]    coll_cnt;
    logic             early, last_try;
    logic [TSV_W-1:0] tsv_nxt;

    assign early    = (byte_cnt <= thr_q);
    assign last_try = (coll_cnt == CW'(MAX_TRIES - 1));

    hdx_tx_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (tx_soft_rst),
        .req_set    (req_set),
        .req_clr    (req_clr),
        .coll       (coll),
        .frame_end  (frame_end),
        .bo_done    (bo_done),
        .early      (early),
        .last_try   (last_try),
        .state      (state),
        .ev_start   (ev_start),
        .ev_restart (ev_restart),
        .ev_backoff (ev_backoff),
        .ev_done    (ev_done),
        .ev_late    (ev_late),
        .ev_excess  (ev_excess)
    );

    hdx_sat_ctr #(.W(CNT_W)) byte_ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_soft_rst | ev_start | ev_restart),
        .inc   (byte_stb && (state == ST_SEND) && !coll && !frame_end),
        .cnt   (byte_cnt)
    );

    hdx_sat_ctr #(.W(CW)) coll_ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ev_start),
        .inc   (ev_backoff),
        .cnt   (coll_cnt)
    );

    assign req   = (state != ST_IDLE);
    assign tx_go = (state == ST_SEND);

    // Late-collision threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_q <= CNT_W'(THR_RESET);
        else if (thr_we)
            thr_q <= thr_in;
    end

    // Backoff start pulse, one cycle after an early collision.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bo_start <= 1'b0;
        else
            bo_start <= ev_backoff;
    end

    // Flags: a setting event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            done_flag <= ev_done | (done_flag & ~flag_clr);
            err_flag  <= ev_late | ev_excess | (err_flag & ~flag_clr);
        end
    end

    // Status word contents for the frame that is finishing now.
    always_comb begin
        tsv_nxt = '0;
        tsv_nxt[TSV_BYTES_W-1:0] = TSV_BYTES_W'(byte_cnt);
        tsv_nxt[TSV_COLL_LSB +: TSV_COLL_W] = ev_done ?
            TSV_COLL_W'(coll_cnt) : TSV_COLL_W'(coll_cnt + CW'(1));
        tsv_nxt[TSV_OK_BIT]    = ev_done;
        tsv_nxt[TSV_ABORT_BIT] = ev_late | ev_excess;
        tsv_nxt[TSV_LATE_BIT]  = ev_late;
        tsv_nxt[TSV_EXC_BIT]   = ev_excess;
    end

    // Status word register, written only when a frame finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tsv <= '0;
        else if (ev_done | ev_late | ev_excess)
            tsv <= tsv_nxt;
    end
endmodule

// File: rtl/hdx_tx_retry_chk.sv
// Checker: temporal properties of the transmit retry controller,
// attached to every instance of the top by the bind below.
module hdx_tx_retry_chk #(
    parameter int CNT_W     = 11,
    parameter int THR_RESET = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_soft_rst,
    input logic             flag_clr,
    input logic             req,
    input logic             tx_go,
    input logic             bo_start,
    input logic             done_flag,
    input logic             err_flag,
    input logic [CNT_W-1:0] thr_q,
    input logic [31:0]      tsv
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (thr_q == CNT_W'(THR_RESET) && !req && !done_flag && !err_flag && tsv == 32'd0));

    a_r3_done_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (!req && tsv[30]));

    a_r4_backoff_idle_wire: assert property (@(posedge clk) disable iff (!rst_n)
        bo_start |-> (req && !tx_go));

    a_r4_backoff_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bo_start |=> !bo_start);

    a_r5_late_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tsv[29]) |-> (err_flag && tsv[31] && !req));

    a_r6_excess_is_abort: assert property (@(posedge clk) disable iff (!rst_n)
        tsv[28] |-> (tsv[31] && !tsv[29] && !tsv[30]));

    a_r9_soft_rst_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_soft_rst) |-> (!req && !tx_go));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !flag_clr) |=> ($stable(done_flag) && $stable(err_flag) && $stable(tsv)));
endmodule

bind hdx_tx_retry_ctrl hdx_tx_retry_chk #(.CNT_W(CNT_W), .THR_RESET(THR_RESET)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_soft_rst (tx_soft_rst),
    .flag_clr    (flag_clr),
    .req         (req),
    .tx_go       (tx_go),
    .bo_start    (bo_start),
    .done_flag   (done_flag),
    .err_flag    (err_flag),
    .thr_q       (thr_q),
    .tsv         (tsv)
);

// File: tb/hdx_tx_retry_ctrl_tb_top.sv
// Bench: directed corner cases plus seeded random frames, checked
// against an outcome model written from the requirements.
module hdx_tx_retry_ctrl_tb_top;
    localparam int CNT_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_set = 1'b0, req_clr = 1'b0, tx_soft_rst = 1'b0, flag_clr = 1'b0;
    logic             thr_we = 1'b0;
    logic [CNT_W-1:0] thr_in = '0;
    logic             byte_stb = 1'b0, frame_end = 1'b0, coll = 1'b0, bo_done = 1'b0;
    logic             req, tx_go, bo_start, done_flag, err_flag;
    logic [CNT_W-1:0] thr_q;
    logic [31:0]      tsv;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    hdx_tx_retry_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
        .tx_soft_rst(tx_soft_rst), .flag_clr(flag_clr), .thr_we(thr_we),
        .thr_in(thr_in), .byte_stb(byte_stb), .frame_end(frame_end),
        .coll(coll), .bo_done(bo_done), .req(req), .tx_go(tx_go),
        .bo_start(bo_start), .done_flag(done_flag), .err_flag(err_flag),
        .thr_q(thr_q), .tsv(tsv)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected status word: kind 0 = done, 1 = late, 2 = excessive.
    function automatic logic [31:0] exp_tsv(int kind, int colls, int nbytes);
        logic [31:0] v = '0;
        v[15:0]  = 16'(nbytes);
        v[20:16] = 5'(colls);
        v[30]    = (kind == 0);
        v[31]    = (kind != 0);
        v[29]    = (kind == 1);
        v[28]    = (kind == 2);
        return v;
    endfunction

    task automatic send_bytes(int n);
        byte_stb = 1'b1;
        repeat (n) tick();
        byte_stb = 1'b0;
    endtask

    task automatic write_thr(int v);
        thr_we = 1'b1; thr_in = CNT_W'(v); tick();
        thr_we = 1'b0;
    endtask

    task automatic clear_flags();
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    endtask

    task automatic start();
        req_set = 1'b1; tick(); req_set = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [31:0] snap;
        void'($urandom(32'h1d5e_0042));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 req", req, 0);
        chk("R1 flags", {done_flag, err_flag, bo_start, tx_go}, 0);
        chk("R1 tsv", tsv, 0);
        chk("R1 thr", thr_q, 64);

        // R12: stimulus while idle changes nothing
        coll = 1'b1; frame_end = 1'b1; bo_done = 1'b1; tick();
        coll = 1'b0; frame_end = 1'b0; bo_done = 1'b0;
        chk("R12 idle outputs", {req, tx_go, bo_start, done_flag, err_flag}, 0);
        chk("R12 idle tsv", tsv, 0);

        // R2 + R3: clean frame; a second request mid-frame is ignored
        start();
        chk("R2 req", {req, tx_go}, 2'b11);
        send_bytes(5);
        req_set = 1'b1; tick(); req_set = 1'b0;
        send_bytes(5);
        frame_end = 1'b1; tick(); frame_end = 1'b0;
        chk("R3 done", {done_flag, err_flag, req}, 3'b100);
        chk("R3 tsv", tsv, exp_tsv(0, 0, 10));

        // R7 + R11: collision with frame end; flag set vs clear same cycle
        start();
        send_bytes(10);
        coll = 1'b1; frame_end = 1'b1; flag_clr = 1'b1; tick();
        coll = 1'b0; frame_end = 1'b0; flag_clr = 1'b0;
        chk("R7 collision wins", {bo_start, done_flag, req, tx_go}, 4'b1010);
        tick();
        bo_done = 1'b1; tick(); bo_done = 1'b0;
        chk("R4 resume", tx_go, 1);
        frame_end = 1'b1; flag_clr = 1'b1; tick(); frame_end = 1'b0; flag_clr = 1'b0;
        chk("R11 set beats clear", done_flag, 1);
        chk("R7 tsv", tsv, exp_tsv(0, 1, 0));
        clear_flags();
        chk("R11 clear", {done_flag, err_flag}, 0);

        // R8 + R5: threshold 3, collision after 4 bytes is late
        write_thr(3);
        chk("R8 thr", thr_q, 3);
        start();
        send_bytes(4);
        coll = 1'b1; tick(); coll = 1'b0;
        chk("R5 late", {err_flag, req, bo_start}, 3'b100);
        chk("R5 tsv", tsv, exp_tsv(1, 1, 4));
        clear_flags();

        // R4 boundary: exactly threshold bytes is early
        start();
        send_bytes(3);
        coll = 1'b1; tick(); coll = 1'b0;
        chk("R4 boundary early", {bo_start, req, err_flag}, 3'b110);
        // R10: cancel during backoff
        req_clr = 1'b1; tick(); req_clr = 1'b0;
        chk("R10 cancel", {req, tx_go, done_flag, err_flag}, 0);
        chk("R10 tsv kept", tsv, exp_tsv(1, 1, 4));

        // R6: sixteen early collisions
        write_thr(64);
        start();
        for (int i = 0; i < 15; i++) begin
            send_bytes(2);
            coll = 1'b1; tick(); coll = 1'b0;
            tick();
            bo_done = 1'b1; tick(); bo_done = 1'b0;
        end
        chk("R6 still going", {req, tx_go, err_flag}, 3'b110);
        send_bytes(2);
        coll = 1'b1; tick(); coll = 1'b0;
        chk("R6 abort", {err_flag, req, bo_start}, 3'b100);
        chk("R6 tsv", tsv, exp_tsv(2, 16, 2));
        clear_flags();

        // R9: soft reset mid-frame, collision ignored, then restart
        snap = tsv;
        start();
        send_bytes(80);
        tx_soft_rst = 1'b1; tick();
        coll = 1'b1; frame_end = 1'b1; req_set = 1'b1; tick();
        coll = 1'b0; frame_end = 1'b0; req_set = 1'b0;
        chk("R9 held idle", {req, tx_go, done_flag, err_flag}, 0);
        chk("R9 tsv kept", tsv, snap);
        tx_soft_rst = 1'b0; tick();
        start();
        chk("R9 restart", req, 1);
        send_bytes(7);
        frame_end = 1'b1; tick(); frame_end = 1'b0;
        chk("R9 fresh count", tsv, exp_tsv(0, 0, 7));
        clear_flags();

        // Random frames against the bench model (R3, R4, R5, R8)
        for (int t = 0; t < 60; t++) begin
            int thr_v, colls, n, kind;
            bit fin;
            thr_v = $urandom % 80;
            write_thr(thr_v);
            chk("R8 rand thr", thr_q, thr_v);
            start();
            colls = 0; fin = 0; kind = 0; n = 0;
            while (!fin) begin
                n = $urandom % 100;
                send_bytes(n);
                if ($urandom % 2 == 1) begin
                    coll = 1'b1; tick(); coll = 1'b0;
                    if (n <= thr_v && colls < 15) begin
                        colls++;
                        chk("R4 rand backoff", {bo_start, tx_go, req}, 3'b101);
                        tick();
                        bo_done = 1'b1; tick(); bo_done = 1'b0;
                        chk("R4 rand resume", tx_go, 1);
                    end else begin
                        kind = (n <= thr_v) ? 2 : 1;
                        colls++;
                        fin = 1;
                    end
                end else begin
                    frame_end = 1'b1; tick(); frame_end = 1'b0;
                    kind = 0; fin = 1;
                end
            end
            chk(kind == 0 ? "R3 rand flags" : "R5 rand flags",
                {done_flag, err_flag, req}, kind == 0 ? 3'b100 : 3'b010);
            chk("R3 R5 rand tsv", tsv, exp_tsv(kind, colls, n));
            clear_flags();
        end

        finish_run();
    end
endmodule